// File: doc/BRIEF.md
# Locality-Biased Memory Traffic Generator

This block is a synthesizable stimulus source for a simple memory bus made of a request strobe, a write enable, a word-aligned byte address, write data and a ready handshake. It emits a run of pseudo-random word transactions whose addresses cluster the way real programs do. The aim is to push a cache placed behind it through hits, misses and dirty write-backs in proportions that uniform addressing would never reach.

Each item is either idle or an access, and an access is either a read or a write. The generator remembers the word address of the last access. Most accesses move a few words up or down from it, and the rest jump to a fresh random word. Stepped addresses that run past either end of the configured power-of-two word range are pinned to the top word. Each item is held on the bus until ready is sampled high. After a fixed number of accepted items the generator stops and raises a done flag. Two seeded maximal-length shift registers supply the randomness: one supplies control decisions and the other supplies write data and jump targets. The starting address is itself drawn from them.

Top module: `loc_traffic_gen`

## Requirements
- R1: While rst_ni is low, req_o, we_o and done_o are 0 and addr_o and wdata_o are all zeros.
- R2: Each item is an access with probability 1/2 (req_o=1) and otherwise idle (req_o=0). Each access is a write (we_o=1) with probability 1/2 and otherwise a read. Over a long run both observed fractions stay within 42% to 58%.
- R3: With probability 3/4 an access addresses the previous access's word plus or minus 0 to 3 words, with the sign equally likely. Otherwise it addresses a uniformly drawn word. Idle items do not change the previous address. Over a run at least 70% of access-to-access moves are such steps (or land on the top word), and at least 3% are not.
- R4: addr_o is a byte address with bits [1:0] zero and every bit at or above position AW+2 zero, so the word index lies in 0 to 2**AW-1.
- R5: A stepped address that would pass the top word, or would fall below word 0, becomes the top word 2**AW-1. As a result the top word is addressed at least 1.5 times as often as the average word.
- R6: An idle item drives we_o=0. Any non-write item drives wdata_o=0. Each write carries a freshly drawn 32-bit word, and at least 90% of consecutive writes carry different data.
- R7: An item stays on the bus, with req_o, we_o, addr_o and wdata_o all unchanged, until a rising clock edge samples ready_i high. The next item appears right after that edge.
- R8: done_o rises right after the edge on which the NUM_ITEMS-th item is accepted, and not earlier. After that it stays high, req_o stays 0 and ready_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_i | input | 1 | Bus accepts the current item at this edge |
| req_o | output | 1 | Access strobe; 0 marks an idle item |
| we_o | output | 1 | Write enable; 0 means read |
| addr_o | output | ADDR_W | Word-aligned byte address |
| wdata_o | output | 32 | Write data, zero for non-writes |
| done_o | output | 1 | Run of NUM_ITEMS items completed |

## Verification
The bench shrinks the range to 16 words, so stepping off either end happens constantly. A generator that wrapped instead of pinning would spread the top word's share evenly, and one that let a decrement borrow would put ones above the range. Moves are measured from the last access with idle items skipped. A generator that advanced on idle items, or that jumped too often, would show too few small steps. Ready is stalled at random, which catches any item that changes before acceptance. The done flag is compared against an exact count of accepted edges, which catches an off-by-one in the run length.

// File: rtl/loc_tg_pkg.sv
`timescale 1ns/1ps
package loc_tg_pkg;

  typedef enum logic [1:0] {ST_INIT, ST_LOAD, ST_WAIT, ST_DONE} tg_state_e;

  typedef struct packed {
    logic       access;
    logic       write;
    logic       jump;
    logic       down;
    logic [1:0] step;
  } tg_ctrl_t;

  localparam int unsigned RND_W = 32;
  // x^32 + x^22 + x^2 + x + 1, Galois right-shift form
  localparam logic [RND_W-1:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [RND_W-1:0] lfsr_adv(input logic [RND_W-1:0] s,
                                                input int unsigned n);
    logic [RND_W-1:0] r;
    r = s;
    for (int i = 0; i < int'(n); i++) begin
      r = r[0] ? ((r >> 1) ^ LFSR_TAPS) : (r >> 1);
    end
    return r;
  endfunction

  // fold all bytes so every random bit contributes
  function automatic tg_ctrl_t decode_ctrl(input logic [RND_W-1:0] r);
    logic [7:0] f;
    tg_ctrl_t   c;
    f        = r[7:0] ^ r[15:8] ^ r[23:16] ^ r[31:24];
    c.access = f[0] ^ f[7];
    c.write  = f[1];
    c.jump   = (f[3:2] == 2'b00);
    c.down   = f[4];
    c.step   = f[6:5];
    return c;
  endfunction

endpackage

// File: rtl/loc_tg_lfsr.sv
`timescale 1ns/1ps
module loc_tg_lfsr #(
  parameter logic [31:0] SEED  = 32'h1,
  parameter int unsigned STEPS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [31:0] rnd_o
);
  localparam logic [31:0] SEED_NZ = (SEED == 32'h0) ? 32'h1 : SEED;

  logic [31:0] rnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rnd_q <= SEED_NZ;
    else if (adv_i) rnd_q <= loc_tg_pkg::lfsr_adv(rnd_q, STEPS);
  end

  assign rnd_o = rnd_q;
endmodule

// File: rtl/loc_tg_addr_next.sv
`timescale 1ns/1ps
module loc_tg_addr_next #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0]        prev_i,
  input  logic [AW-1:0]        jump_word_i,
  input  loc_tg_pkg::tg_ctrl_t ctrl_i,
  output logic [AW-1:0]        next_o
);
  logic [AW:0] stepped;
  logic [AW:0] step_ext;

  always_comb begin
    step_ext = (AW+1)'(ctrl_i.step);
    stepped  = ctrl_i.down ? ({1'b0, prev_i} - step_ext)
                           : ({1'b0, prev_i} + step_ext);
    // carry or borrow out of the range pins to the top word
    if (ctrl_i.jump)     next_o = jump_word_i;
    else if (stepped[AW]) next_o = '1;
    else                 next_o = stepped[AW-1:0];
  end
endmodule

// File: rtl/loc_tg_run_counter.sv
`timescale 1ns/1ps
module loc_tg_run_counter #(
  parameter int unsigned NUM_ITEMS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (NUM_ITEMS > 2) ? $clog2(NUM_ITEMS) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(NUM_ITEMS - 1));
endmodule

// File: rtl/loc_traffic_gen.sv
`timescale 1ns/1ps
module loc_traffic_gen #(
  parameter int unsigned AW         = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_ITEMS  = 10000,
  parameter int unsigned DRAW_STEPS = 32,
  parameter logic [31:0] SEED_CTRL  = 32'hACE1_2468,
  parameter logic [31:0] SEED_DATA  = 32'h1357_BEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  output logic              done_o
);
  import loc_tg_pkg::*;

  localparam int unsigned PAD_W = ADDR_W - AW - 2;

  tg_state_e   state_q;
  logic [AW-1:0] prev_q;
  logic [31:0] rnd [2];
  logic        adv;
  logic        accept;
  logic        last;
  tg_ctrl_t    ctrl;
  logic [AW-1:0] jump_word;
  logic [AW-1:0] next_word;

  logic              it_req;
  logic              it_we;
  logic [ADDR_W-1:0] it_addr;
  logic [31:0]       it_wdata;
  logic [AW-1:0]     it_prev;

  assign accept = (state_q == ST_WAIT) && ready_i;
  assign adv    = (state_q == ST_INIT) || (state_q == ST_LOAD) || accept;

  // source 0: control decisions, source 1: data and jump targets
  for (genvar g = 0; g < 2; g++) begin : g_src
    loc_tg_lfsr #(
      .SEED (g == 0 ? SEED_CTRL : SEED_DATA),
      .STEPS(DRAW_STEPS)
    ) u_lfsr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (adv),
      .rnd_o (rnd[g])
    );
  end

  assign ctrl      = decode_ctrl(rnd[0]);
  assign jump_word = rnd[1][31 -: AW];

  loc_tg_addr_next #(.AW(AW)) u_addr (
    .prev_i     (prev_q),
    .jump_word_i(jump_word),
    .ctrl_i     (ctrl),
    .next_o     (next_word)
  );

  loc_tg_run_counter #(.NUM_ITEMS(NUM_ITEMS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept),
    .last_o(last)
  );

  always_comb begin
    it_req   = ctrl.access;
    it_we    = ctrl.access && ctrl.write;
    it_addr  = ctrl.access ? {{PAD_W{1'b0}}, next_word, 2'b00} : addr_o;
    it_wdata = it_we ? rnd[1] : 32'h0;
    it_prev  = ctrl.access ? next_word : prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      prev_q  <= '0;
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_INIT: begin
          prev_q  <= jump_word;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          req_o   <= it_req;
          we_o    <= it_we;
          addr_o  <= it_addr;
          wdata_o <= it_wdata;
          prev_q  <= it_prev;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ready_i) begin
            if (last) begin
              req_o   <= 1'b0;
              we_o    <= 1'b0;
              wdata_o <= '0;
              done_o  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              req_o   <= it_req;
              we_o    <= it_we;
              addr_o  <= it_addr;
              wdata_o <= it_wdata;
              prev_q  <= it_prev;
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/loc_traffic_gen_chk.sv
`timescale 1ns/1ps
module loc_traffic_gen_chk #(
  parameter int unsigned AW     = 16,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [31:0]       wdata_o,
  input logic              done_o
);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i && !done_o) |=>
      (req_o && $stable(we_o) && $stable(addr_o) && $stable(wdata_o)));

  assert_addr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[1:0] == 2'b00) && ((addr_o >> (AW + 2)) == '0));

  assert_idle_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> !we_o);

  assert_nonwrite_zero_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> (wdata_o == 32'h0));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !req_o));
endmodule

bind loc_traffic_gen loc_traffic_gen_chk #(.AW(AW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready_i(ready_i),
  .req_o  (req_o),
  .we_o   (we_o),
  .addr_o (addr_o),
  .wdata_o(wdata_o),
  .done_o (done_o)
);

// File: tb/tb_loc_traffic_gen.sv
`timescale 1ns/1ps
module tb_loc_traffic_gen;
  localparam int unsigned AW     = 4;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned N      = 3000;
  localparam int          TOPW   = (1 << AW) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ready_i = 1'b0;
  logic              req_o, we_o, done_o;
  logic [ADDR_W-1:0] addr_o;
  logic [31:0]       wdata_o;

  always #2.5 clk_i = ~clk_i;

  loc_traffic_gen #(.AW(AW), .ADDR_W(ADDR_W), .NUM_ITEMS(N)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i),
    .req_o(req_o), .we_o(we_o), .addr_o(addr_o),
    .wdata_o(wdata_o), .done_o(done_o)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && ((a >> (AW + 2)) == '0);
  endfunction

  function automatic bit is_local(input int a, input int b);
    int d;
    d = b - a;
    return ((d >= -3) && (d <= 3)) || (b == TOPW);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int accepted, items, acc, wr, loc, nonloc, top_cnt, fresh;
    int last_word, w;
    bit have_acc, have_wr, started, prev_ready, r;
    logic [31:0] last_wdata;
    logic              s_req, s_we;
    logic [ADDR_W-1:0] s_addr;
    logic [31:0]       s_wdata;

    void'($urandom(32'd20240607));
    accepted = 0; items = 0; acc = 0; wr = 0; loc = 0; nonloc = 0;
    top_cnt = 0; fresh = 0; last_word = 0; have_acc = 0; have_wr = 0;
    last_wdata = '0; prev_ready = 0; started = 0;
    s_req = 0; s_we = 0; s_addr = '0; s_wdata = '0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_o == 1'b0, "R1", "req_o in reset", req_o, 0);
    chk(we_o == 1'b0, "R1", "we_o in reset", we_o, 0);
    chk(done_o == 1'b0, "R1", "done_o in reset", done_o, 0);
    chk(addr_o == '0, "R1", "addr_o in reset", addr_o, 0);
    chk(wdata_o == '0, "R1", "wdata_o in reset", wdata_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    started = 1;
    s_req = req_o; s_we = we_o; s_addr = addr_o; s_wdata = wdata_o;

    while (accepted < int'(N)) begin
      // decide ready for the coming edge; item visible now is accepted if r
      r = (($urandom % 10) < 6);
      ready_i = r;
      if (r) begin
        accepted++;
        items++;
        if (req_o) begin
          acc++;
          w = int'(addr_o >> 2);
          if (w == TOPW) top_cnt++;
          if (have_acc) begin
            if (is_local(last_word, w)) loc++;
            else nonloc++;
          end
          last_word = w;
          have_acc = 1;
          if (we_o) begin
            wr++;
            if (have_wr && (wdata_o != last_wdata)) fresh++;
            last_wdata = wdata_o;
            have_wr = 1;
          end
        end
      end
      prev_ready = r;
      @(negedge clk_i);
      // R7: unaccepted item must stay on the bus
      if (started && !prev_ready) begin
        chk((req_o == s_req) && (we_o == s_we) && (addr_o == s_addr) && (wdata_o == s_wdata),
            "R7", "item changed without ready", addr_o, s_addr);
      end
      s_req = req_o; s_we = we_o; s_addr = addr_o; s_wdata = wdata_o;
      // R8: done exactly after N accepts
      chk(done_o == (accepted >= int'(N)), "R8", "done_o vs accepted count",
          done_o, (accepted >= int'(N)));
      chk(addr_ok(addr_o), "R4", "address out of range or unaligned", addr_o, 0);
      chk(req_o || !we_o, "R6", "we_o on idle item", we_o, 0);
      chk(we_o || (wdata_o == '0), "R6", "wdata_o on non-write", wdata_o, 0);
    end

    // R8: after done, ready has no effect and the bus stays quiet
    for (int i = 0; i < 20; i++) begin
      ready_i = i[0];
      @(negedge clk_i);
      chk(done_o == 1'b1, "R8", "done_o sticky", done_o, 1);
      chk(req_o == 1'b0, "R8", "req_o after done", req_o, 0);
    end

    // R2 access and write ratios
    chk((acc * 100 >= items * 42) && (acc * 100 <= items * 58), "R2",
        "access percent", acc * 100 / items, 50);
    chk((wr * 100 >= acc * 42) && (wr * 100 <= acc * 58), "R2",
        "write percent of accesses", wr * 100 / acc, 50);
    // R3 locality mix
    chk(loc * 100 >= (loc + nonloc) * 70, "R3", "local step percent",
        loc * 100 / (loc + nonloc), 70);
    chk(nonloc * 100 >= (loc + nonloc) * 3, "R3", "jump percent",
        nonloc * 100 / (loc + nonloc), 3);
    // R5 clamp concentrates traffic on the top word
    chk(top_cnt * (TOPW + 1) * 2 >= acc * 3, "R5", "top word hits x100/avg",
        top_cnt * (TOPW + 1) * 100 / acc, 150);
    // R6 write data freshness
    chk(fresh * 10 >= (wr - 1) * 9, "R6", "fresh write data count", fresh, wr - 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule